// File: doc/BRIEF.md
# Multiplexed Bank Row Column Address Latch

This block sits on the memory side of a clock-sampled command/address interface for an eight-bank memory whose address pins are shared between row and column phases. An activate command records a row number for the addressed bank and marks that bank open. A later read or write command supplies only the column bits. The block joins that column with the row already held for the same bank and presents the complete in-bank word address as a one-cycle access strobe.

Each bank keeps its own open flag and stored row, so up to eight pages can be open at once. A bank closes on an explicit page-close command, or straight after the access when the read or write uses its auto-close form. A column command to a closed bank is rejected with a one-cycle error pulse. An activate aimed at a bank that is already open is also flagged, and the row that is already stored is kept. Command timing rules and refresh belong to other logic.

Top module: `bank_addr_latch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, no bank is open and `acc_valid`, `err_closed` and `err_reopen` are low.
- R2: An activate (`cmd` = 3'd1) to a closed bank opens that bank from the next cycle and stores `cmd_addr[10:0]` as its row.
- R3: A read (3'd2) or write (3'd3) to an open bank gives `acc_valid` high for exactly the next cycle. In that cycle `acc_write` is 1 for writes, `acc_bank` is the bank, and `acc_addr` = {stored row, `cmd_addr[6:0]`}. Bits `cmd_addr[10:7]` have no effect on a column command.
- R4: The auto-close read (3'd4) and write (3'd5) produce the same access as R3, and the bank is closed from the next cycle.
- R5: A page-close (3'd6) closes the addressed bank from the next cycle. Closing a bank that is already closed raises no error and changes nothing.
- R6: A read or write of either form to a closed bank raises `err_closed` for the next cycle only, with `acc_valid` low and no change to any bank.
- R7: An activate to an open bank raises `err_reopen` for the next cycle and leaves that bank's stored row and open state unchanged.
- R8: Every bank keeps its own row and open flag. A command changes only the bank named by `cmd_bank`.
- R9: With `cmd_valid` low, or with `cmd` = 3'd0 or 3'd7, nothing changes and neither a strobe nor an error appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Command code (see R2 to R9) |
| cmd_bank | input | 3 | Bank selected by the command |
| cmd_addr | input | 11 | Shared address bus: row on activate, column in bits 6:0 otherwise |
| acc_valid | output | 1 | One-cycle access strobe |
| acc_write | output | 1 | Access is a write |
| acc_bank | output | 3 | Bank of the last access or error |
| acc_addr | output | 18 | In-bank word address {row, column} |
| err_closed | output | 1 | Column command hit a closed bank |
| err_reopen | output | 1 | Activate hit an open bank |
| bank_open | output | 8 | Open flag of each bank |

## Verification
The bench sweeps all 128 columns on every bank with the upper address bits set, so a design that took column bits from the wrong slice, or mixed in row bits, shows a wrong `acc_addr`. It tries a second activate with a new row on an open bank and then reads it. A design that overwrote the row on the rejected activate returns the new row instead of the first one. Page-close of a closed bank, reads after auto-close, and idle or reserved codes are aimed at designs that raise spurious errors, forget to close the bank, or act on a command that is not valid. A long pseudo-random command stream, checked against a per-bank model, catches any command leaking into a bank it did not name.

// File: rtl/bank_addr_latch.sv
module bank_addr_latch #(
  parameter int BANKS = 8,
  parameter int ROW_W = 11,
  parameter int COL_W = 7,
  localparam int BA_W = $clog2(BANKS),
  localparam int AW   = ROW_W + COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0] cmd_addr,
  output logic            acc_valid,
  output logic            acc_write,
  output logic [BA_W-1:0] acc_bank,
  output logic [AW-1:0]   acc_addr,
  output logic            err_closed,
  output logic            err_reopen,
  output logic [BANKS-1:0] bank_open
);
  localparam logic [2:0] OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                         OP_RDA = 3'd4, OP_WRA = 3'd5, OP_PC = 3'd6;

  logic [ROW_W-1:0] row_q [BANKS];

  wire is_act  = cmd_valid && cmd == OP_ACT;
  wire is_pc   = cmd_valid && cmd == OP_PC;
  wire is_col  = cmd_valid && (cmd == OP_RD || cmd == OP_WR || cmd == OP_RDA || cmd == OP_WRA);
  wire is_auto = cmd == OP_RDA || cmd == OP_WRA;
  wire is_wr   = cmd == OP_WR || cmd == OP_WRA;
  wire hit_open = bank_open[cmd_bank];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    wire sel = cmd_bank == BA_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[g] <= 1'b0;
        row_q[g]     <= '0;
      end else if (sel) begin
        if (is_act && !bank_open[g]) begin
          bank_open[g] <= 1'b1;
          row_q[g]     <= cmd_addr;
        end else if (is_pc || (is_col && is_auto && bank_open[g])) begin
          bank_open[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid  <= 1'b0;
      acc_write  <= 1'b0;
      acc_bank   <= '0;
      acc_addr   <= '0;
      err_closed <= 1'b0;
      err_reopen <= 1'b0;
    end else begin
      acc_valid  <= is_col && hit_open;
      err_closed <= is_col && !hit_open;
      err_reopen <= is_act && hit_open;
      if (is_col || (is_act && hit_open))
        acc_bank <= cmd_bank;
      if (is_col && hit_open) begin
        acc_write <= is_wr;
        acc_addr  <= {row_q[cmd_bank], cmd_addr[COL_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/bank_addr_latch_chk.sv
module bank_addr_latch_chk #(
  parameter int BANKS = 8,
  parameter int BA_W  = 3,
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd,
  input logic [BA_W-1:0]  cmd_bank,
  input logic             acc_valid,
  input logic [BA_W-1:0]  acc_bank,
  input logic             err_closed,
  input logic             err_reopen,
  input logic [BANKS-1:0] bank_open
);
  logic [BANKS-1:0] prev_open;
  always_ff @(posedge clk)
    if (!rst_n) prev_open <= '0;
    else        prev_open <= bank_open;

  // R6
  no_strobe_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_closed |-> !acc_valid);
  // R3
  access_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> prev_open[acc_bank]);
  // R2
  act_leaves_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 3'd1) |=> bank_open[$past(cmd_bank)]);
  // R5
  page_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 3'd6) |=> !bank_open[$past(cmd_bank)]);
  // R4
  auto_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd == 3'd4 || cmd == 3'd5)) |=> !bank_open[$past(cmd_bank)]);
  // R7
  reopen_was_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_reopen |-> (prev_open[acc_bank] && !acc_valid && !err_closed));
endmodule

bind bank_addr_latch bank_addr_latch_chk #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bank(cmd_bank),
  .acc_valid(acc_valid), .acc_bank(acc_bank), .err_closed(err_closed),
  .err_reopen(err_reopen), .bank_open(bank_open));

// File: tb/test_bank_addr_latch.sv
module test_bank_addr_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd = '0, cmd_bank = '0;
  logic [10:0] cmd_addr = '0;
  logic acc_valid, acc_write, err_closed, err_reopen;
  logic [2:0] acc_bank;
  logic [17:0] acc_addr;
  logic [7:0] bank_open;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_addr_latch i_bank_addr_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .acc_valid(acc_valid), .acc_write(acc_write), .acc_bank(acc_bank),
    .acc_addr(acc_addr), .err_closed(err_closed), .err_reopen(err_reopen), .bank_open(bank_open));

  int checks = 0, fails = 0;
  logic [7:0]  m_open = '0;
  logic [10:0] m_row [8];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic v, logic [2:0] c, logic [2:0] b, logic [10:0] a);
    logic ev, ec, er, ew;
    logic [17:0] ea;
    string tag;
    cmd_valid = v; cmd = c; cmd_bank = b; cmd_addr = a;
    ev = 0; ec = 0; er = 0; ew = (c == 3'd3 || c == 3'd5); ea = {m_row[b], a[6:0]};
    tag = "R9";
    if (v) begin
      case (c)
        3'd1: begin
          tag = m_open[b] ? "R7" : "R2";
          if (m_open[b]) er = 1;
          else begin m_open[b] = 1; m_row[b] = a; end
        end
        3'd2, 3'd3, 3'd4, 3'd5: begin
          tag = (c >= 3'd4) ? "R4" : "R3";
          if (!m_open[b]) begin ec = 1; tag = "R6"; end
          else begin ev = 1; if (c >= 3'd4) m_open[b] = 0; end
        end
        3'd6: begin tag = "R5"; m_open[b] = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " strobe/err"}, {29'd0, acc_valid, err_closed, err_reopen}, {29'd0, ev, ec, er});
    check({tag, " open (R8)"}, {24'd0, bank_open}, {24'd0, m_open});
    if (ev) check({tag, " access"}, {10'd0, acc_write, acc_bank, acc_addr}, {10'd0, ew, b, ea});
    if (ec || er) check({tag, " err bank"}, {29'd0, acc_bank}, {29'd0, b});
    cmd_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) m_row[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {21'd0, bank_open, acc_valid, err_closed, err_reopen}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {21'd0, bank_open, acc_valid, err_closed, err_reopen}, 32'd0);

    // R2, R8: open every bank with a distinct row
    for (int b = 0; b < 8; b++) issue(1, 3'd1, 3'(b), 11'(b * 255 + 7));
    // R3: full column sweep, upper bits set to show they are ignored
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 128; c++)
        issue(1, (c % 2) ? 3'd3 : 3'd2, 3'(b), 11'h780 | 11'(c));
    // R7: reopen with another row, then read to see the old row
    issue(1, 3'd1, 3'd2, 11'h555);
    issue(1, 3'd2, 3'd2, 11'h011);
    // R5: close, close again, then R6 read of closed bank
    issue(1, 3'd6, 3'd3, 11'h000);
    issue(1, 3'd6, 3'd3, 11'h000);
    issue(1, 3'd2, 3'd3, 11'h005);
    issue(1, 3'd3, 3'd3, 11'h005);
    // R4: auto-close forms, then access of the closed bank
    issue(1, 3'd4, 3'd5, 11'h07F);
    issue(1, 3'd2, 3'd5, 11'h001);
    issue(1, 3'd5, 3'd6, 11'h040);
    issue(1, 3'd5, 3'd6, 11'h040);
    // R9: invalid or reserved commands
    issue(0, 3'd1, 3'd3, 11'h123);
    issue(0, 3'd2, 3'd0, 11'h001);
    issue(1, 3'd0, 3'd0, 11'h001);
    issue(1, 3'd7, 3'd0, 11'h001);
    issue(1, 3'd2, 3'd0, 11'h002);

    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[15:14] != 2'b00, lfsr[2:0], lfsr[5:3], lfsr[15:5]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule